// File: doc/BRIEF.md
# Biphase-Mark Line Encoder

This block turns a serial bit stream into a biphase-mark line signal, also called differential Manchester. It runs on a fast system clock. Alongside each data bit it receives a half-cell clock. That clock is high for the first half of the bit cell and low for the second half. The block samples both inputs on the system clock and finds the half-cell clock's edges from consecutive samples. It drives one registered line level.

A rising edge of the half-cell clock opens a new bit cell. At that edge the line always inverts, and the data bit is captured. A falling edge marks the middle of the cell. There the line inverts a second time only when the captured bit is 1. A captured 0 leaves the line steady until the next cell starts. The data clock is generated outside the block, and so is any framing. A decoder is not part of this block.

The parameter `SYNC_STAGES` sets how many sampling registers the inputs pass through before edge detection. Its default is 1.

Top module: `bmcEncoder`

## Requirements
- R1: While `rst` is high, `lineOut` is low from the next rising clock edge on. After release with `halfClkIn` low, `lineOut` stays low until the first rising edge of `halfClkIn`.
- R2: Every low-to-high change of `halfClkIn` inverts `lineOut` exactly once, whatever the data value.
- R3: At a high-to-low change of `halfClkIn`, `lineOut` inverts if the bit captured at the preceding rising edge was 1.
- R4: At a high-to-low change of `halfClkIn`, `lineOut` keeps its level if the bit captured at the preceding rising edge was 0.
- R5: The data bit is the `dataIn` value sampled together with the rising edge of `halfClkIn`. Any later change of `dataIn` inside the same cell has no effect on the mid-cell decision or on `lineOut`.
- R6: With the default `SYNC_STAGES` of 1, `lineOut` settles within two rising system-clock edges of an input change. While `halfClkIn` does not change, `lineOut` does not change.
- R7: Reset is synchronous and active high. If reset is applied mid-stream, the line returns low. The edge detector also restarts from a low sample, so a `halfClkIn` held high across the release counts as a new cell start. In that case the line goes high and `dataIn` is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; inputs are expected to change on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| halfClkIn | input | 1 | Half-cell clock: high in the first half of a bit cell, low in the second |
| dataIn | input | 1 | Serial data bit for the current cell |
| lineOut | output | 1 | Registered biphase-mark line level |

## Verification
The bench sends runs of all zeros, runs of all ones and a mixed pattern. These catch a design that inverts at the wrong half-cell, or one that misses the boundary inversion for a 0 bit. It changes `dataIn` in the middle of the first half-cell in both directions. A design that reads live data at the mid-cell edge, instead of the captured bit, would then add or drop an inversion.

Each result is read two system clocks after the input change, and read again two clocks later. This catches extra pipeline delay as well as spurious toggles while the clock is steady. A reset applied while `halfClkIn` is high shows whether the edge detector restarts cleanly. A design that kept its old sample would miss the new cell start or produce a stale level.

// File: rtl/bmcPkg.sv
package bmcPkg;
  // Strobes passed from control to datapath, valid for one system clock.
  typedef struct packed {
    logic bitStart;     // half-cell clock rose: new bit cell
    logic midCell;      // half-cell clock fell: middle of the cell
    logic sampledData;  // data bit sampled alongside the half-cell clock
  } bmcStrobeT;
endpackage

// File: rtl/bmcCtrl.sv
module bmcCtrl
  import bmcPkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      halfClkIn,
  input  logic      dataIn,
  output bmcStrobeT strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic                   clkPrev;

  // Sampling chain; data travels beside the clock so they stay aligned.
  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            clkSync[i]  <= 1'b0;
            dataSync[i] <= 1'b0;
          end else begin
            clkSync[i]  <= halfClkIn;
            dataSync[i] <= dataIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            clkSync[i]  <= 1'b0;
            dataSync[i] <= 1'b0;
          end else begin
            clkSync[i]  <= clkSync[i-1];
            dataSync[i] <= dataSync[i-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clkPrev <= 1'b0;
    else     clkPrev <= clkSync[LAST];
  end

  always_comb begin
    strobe.bitStart    = clkSync[LAST] & ~clkPrev;
    strobe.midCell     = ~clkSync[LAST] & clkPrev;
    strobe.sampledData = dataSync[LAST];
  end
endmodule

// File: rtl/bmcDatapath.sv
module bmcDatapath
  import bmcPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bmcStrobeT strobe,
  output logic      lineOut
);
  logic bitLatch;
  logic lineReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitLatch <= 1'b0;
      lineReg  <= 1'b0;
    end else if (strobe.bitStart) begin
      bitLatch <= strobe.sampledData;
      lineReg  <= ~lineReg;
    end else if (strobe.midCell && bitLatch) begin
      lineReg  <= ~lineReg;
    end
  end

  assign lineOut = lineReg;

  // R1: reset drives the line low.
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !lineReg)
    else $error("R1 line not low after reset");

  // R2: a cell start always inverts the line.
  p_start_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.bitStart |=> lineReg != $past(lineReg))
    else $error("R2 missing boundary inversion");

  // R3: a captured 1 inverts the line at mid-cell.
  p_mid_one_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.midCell && bitLatch) |=> lineReg != $past(lineReg))
    else $error("R3 missing mid-cell inversion");

  // R4: a captured 0 holds the line at mid-cell.
  p_mid_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.midCell && !bitLatch) |=> $stable(lineReg))
    else $error("R4 unexpected mid-cell inversion");

  // R6: no half-cell edge, no line change.
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!strobe.bitStart && !strobe.midCell) |=> $stable(lineReg))
    else $error("R6 line moved without an edge");
endmodule

// File: rtl/bmcEncoder.sv
module bmcEncoder
  import bmcPkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic halfClkIn,
  input  logic dataIn,
  output logic lineOut
);
  bmcStrobeT strobe;

  bmcCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .halfClkIn (halfClkIn),
    .dataIn    (dataIn),
    .strobe    (strobe)
  );

  bmcDatapath u_data (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .lineOut (lineOut)
  );
endmodule

// File: tb/tb_bmcEncoder.sv
module tb_bmcEncoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halfClk = 1'b0;
  logic dataIn = 1'b0;
  logic lineOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  logic expLine = 1'b0;
  logic expBit = 1'b0;
  logic prevClk = 1'b0;

  always #10 clk = ~clk;

  bmcEncoder dut (
    .clk       (clk),
    .rst       (rst),
    .halfClkIn (halfClk),
    .dataIn    (dataIn),
    .lineOut   (lineOut)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: lineOut=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Drive one input state, then check the line early (latency) and late (stable).
  task automatic halfCell(input logic c, input logic d, input string tag);
    @(negedge clk);
    halfClk = c;
    dataIn  = d;
    if (c && !prevClk) begin
      expLine = ~expLine;
      expBit  = d;
    end else if (!c && prevClk && expBit) begin
      expLine = ~expLine;
    end
    prevClk = c;
    repeat (2) @(negedge clk);
    check({tag, " R6 latency"}, lineOut, expLine);
    repeat (2) @(negedge clk);
    check({tag, " R6 stable"}, lineOut, expLine);
  endtask

  task automatic sendBit(input logic d, input string tag);
    halfCell(1'b1, d, tag);
    halfCell(1'b0, d, tag);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 during reset", lineOut, 1'b0);
    rst = 1'b0;
    expLine = 1'b0; expBit = 1'b0; prevClk = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 idle after release", lineOut, 1'b0);
  endtask

  task automatic testZeros();
    for (int k = 0; k < 4; k++) sendBit(1'b0, "R2 R4 zeros");
  endtask

  task automatic testOnes();
    for (int k = 0; k < 4; k++) sendBit(1'b1, "R2 R3 ones");
  endtask

  task automatic testMixed();
    logic [7:0] pattern = 8'b1011_0010;
    for (int k = 7; k >= 0; k--) sendBit(pattern[k], "R2 R3 R4 mixed");
  endtask

  task automatic testLateData();
    // captured 1, data drops during first half: mid-cell must still invert
    halfCell(1'b1, 1'b1, "R5 capture one");
    halfCell(1'b1, 1'b0, "R5 late drop ignored");
    halfCell(1'b0, 1'b0, "R5 mid uses captured one");
    // captured 0, data rises during first half: mid-cell must hold
    halfCell(1'b1, 1'b0, "R5 capture zero");
    halfCell(1'b1, 1'b1, "R5 late rise ignored");
    halfCell(1'b0, 1'b1, "R5 mid uses captured zero");
  endtask

  task automatic testMidReset();
    sendBit(1'b1, "R7 pre");
    halfCell(1'b1, 1'b1, "R7 before reset");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 line low in reset", lineOut, 1'b0);
    rst = 1'b0;
    // edge detector restarts from low: held-high clock is a new cell
    expLine = 1'b1; expBit = dataIn; prevClk = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 restart cell high", lineOut, expLine);
    halfCell(1'b0, 1'b1, "R7 mid after restart");
    sendBit(1'b0, "R7 post");
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testReset();
    testZeros();
    testOnes();
    testMixed();
    testLateData();
    testMidReset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule